// File: doc/BRIEF.md
# Byte-Wide Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic core of a small byte-oriented processor. It holds three 8-bit registers: an accumulator, a second operand register and a condition-flag byte. Either operand register can be written through its own load port. On a clock edge where the execute strobe is high, the unit applies the selected operation to the accumulator and the second operand. It writes the result back into the accumulator and rebuilds the flag byte from that result.

There are eight operations. Four are arithmetic: add, add with carry-in, subtract, and subtract with borrow-in. Three are bitwise: AND, XOR and OR. The last is compare, which sets the flags as a subtract would but leaves the accumulator as it was. Instruction decoding and bus traffic belong to the surrounding logic. The unit only sees operands, an operation code and a strobe. It has no multi-cycle sequencing, so every operation completes on the edge that samples the strobe.

Top module: `alu8_unit`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises, the accumulator and operand registers read 0x00 and the flag byte reads 0x02.
- R2: With exec low, acc_load copies acc_din into the accumulator at the next rising edge. tmp_load copies tmp_din into the operand register at the next rising edge whatever exec is. Neither load changes the flag byte.
- R3: op code 0 (add) stores A+T and op code 1 (add with carry) stores A+T+CY, both modulo 256. CY becomes the carry out of bit 7.
- R4: op code 2 (subtract) stores A-T and op code 3 (subtract with borrow) stores A-T-CY, both modulo 256. CY becomes 1 exactly when the true difference is negative.
- R5: op codes 4 (AND), 5 (XOR) and 6 (OR) store the bitwise result. Each clears CY. AC becomes 1 after AND and 0 after XOR or OR.
- R6: op code 7 (compare) sets every flag exactly as op code 2 would for the same operands, and the accumulator keeps its value.
- R7: The flag byte holds S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R8: For arithmetic operations AC is the carry out of bit 3 of the internal sum. For add that sum is A+T+cin. For subtract and compare it is A+(~T)+cin, where cin is 1 without borrow and 1-CY with borrow.
- R9: S equals bit 7 of the 8-bit result. Z is 1 exactly when that result is 0x00. P is 1 exactly when the result holds an even number of 1 bits.
- R10: The flag byte changes only on an edge with exec high. When exec and acc_load are both high, the operation's write-back wins and acc_din is ignored. With compare, the accumulator is left unchanged.
- R11: An operation uses the register values from before its edge. A tmp_load on the same edge only affects later operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_load | input | 1 | Write acc_din into the accumulator |
| acc_din | input | 8 | Accumulator load value |
| tmp_load | input | 1 | Write tmp_din into the operand register |
| tmp_din | input | 8 | Operand register load value |
| exec | input | 1 | Execute strobe: perform op on this edge |
| op | input | 3 | Operation code (0..7, see R3 to R6) |
| acc_q | output | 8 | Accumulator contents |
| tmp_q | output | 8 | Operand register contents |
| flags_q | output | 8 | Condition-flag byte |

## Verification
The embedded properties check the following on every cycle:
- the fixed bits and layout of the flag byte;
- that S, Z and P agree with the accumulator after each written-back operation;
- that bitwise operations clear CY and set AC only for AND;
- that the flags are frozen without exec and compare leaves the accumulator alone.

Only the bench's scenarios can show that the arithmetic values are correct. The same holds for the borrow sense of CY, the carry out of bit 3 for subtracts, the carry-in chaining, and the priority and timing rules between loads and execution.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    // bit positions inside the flag byte (R7)
    localparam int FB_CY = 0;
    localparam int FB_K1 = 1;
    localparam int FB_P  = 2;
    localparam int FB_K3 = 3;
    localparam int FB_AC = 4;
    localparam int FB_K5 = 5;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    localparam logic [7:0] FLAG_FIXED_ONES = 8'h02;

endpackage

// File: rtl/alu8_datapath.sv
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opt,
    input  alu_op_e           op,
    input  logic              cy_in,
    output logic [DATA_W-1:0] res,
    output logic              cy_out,
    output logic              ac_out,
    output logic              wb_en
);
    localparam int HALF_W = DATA_W / 2;

    logic              is_sub;
    logic              is_arith;
    logic              cin;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W:0]   full_sum;
    logic [HALF_W:0]   low_sum;

    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        is_arith = is_sub || (op == OP_ADD) || (op == OP_ADC);
        opnd     = is_sub ? ~opt : opt;
        unique case (op)
            OP_ADC:  cin = cy_in;
            OP_SUB:  cin = 1'b1;
            OP_CMP:  cin = 1'b1;
            OP_SBB:  cin = ~cy_in;
            default: cin = 1'b0;
        endcase
        full_sum = {1'b0, opa} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
        low_sum  = {1'b0, opa[HALF_W-1:0]} + {1'b0, opnd[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin};
    end

    always_comb begin
        wb_en = (op != OP_CMP);
        if (is_arith) begin
            res    = full_sum[DATA_W-1:0];
            cy_out = is_sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
            ac_out = low_sum[HALF_W];
        end else begin
            unique case (op)
                OP_AND:  res = opa & opt;
                OP_XOR:  res = opa ^ opt;
                default: res = opa | opt;
            endcase
            cy_out = 1'b0;
            ac_out = (op == OP_AND);
        end
    end

endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cy,
    input  logic              ac,
    output logic [7:0]        flag_byte
);
    always_comb begin
        flag_byte        = FLAG_FIXED_ONES;
        flag_byte[FB_S]  = res[DATA_W-1];
        flag_byte[FB_Z]  = (res == '0);
        flag_byte[FB_AC] = ac;
        flag_byte[FB_P]  = ~^res;
        flag_byte[FB_CY] = cy;
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_load,
    input  logic [DATA_W-1:0] acc_din,
    input  logic              tmp_load,
    input  logic [DATA_W-1:0] tmp_din,
    input  logic              exec,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] tmp_q,
    output logic [7:0]        flags_q
);
    alu_op_e           op_e;
    logic [DATA_W-1:0] dp_res;
    logic              dp_cy;
    logic              dp_ac;
    logic              dp_wb;
    logic [7:0]        next_flags;

    assign op_e = alu_op_e'(op);

    alu8_datapath #(.DATA_W(DATA_W)) u_dp (
        .opa    (acc_q),
        .opt    (tmp_q),
        .op     (op_e),
        .cy_in  (flags_q[FB_CY]),
        .res    (dp_res),
        .cy_out (dp_cy),
        .ac_out (dp_ac),
        .wb_en  (dp_wb)
    );

    alu8_flagpack #(.DATA_W(DATA_W)) u_fp (
        .res       (dp_res),
        .cy        (dp_cy),
        .ac        (dp_ac),
        .flag_byte (next_flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            tmp_q   <= '0;
            flags_q <= FLAG_FIXED_ONES;
        end else begin
            if (tmp_load) tmp_q <= tmp_din;
            if (exec) begin
                flags_q <= next_flags;
                if (dp_wb) acc_q <= dp_res;
            end else if (acc_load) begin
                acc_q <= acc_din;
            end
        end
    end

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[FB_K1] && !flags_q[FB_K3] && !flags_q[FB_K5]);  // R7
    AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(flags_q));  // R10
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 3'd7) |=> $stable(acc_q));  // R6
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op != 3'd7) |=> flags_q[FB_Z] == (acc_q == '0));  // R9
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op != 3'd7) |=> flags_q[FB_S] == acc_q[DATA_W-1]);  // R9
    AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op != 3'd7) |=> flags_q[FB_P] == ($countones(acc_q) % 2 == 0));  // R9
    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op[2] && op != 3'd7) |=>
            !flags_q[FB_CY] && (flags_q[FB_AC] == ($past(op) == 3'd4)));  // R5

endmodule

// File: tb/alu8_unit_tb.sv
`timescale 1ns/1ps
module alu8_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_load, tmp_load, exec;
    logic [7:0] acc_din, tmp_din;
    logic [2:0] op;
    logic [7:0] acc_q, tmp_q, flags_q;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    int m_acc, m_tmp, m_cy;
    int m_flags;

    always #4 clk = ~clk;

    alu8_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_load(acc_load), .acc_din(acc_din),
        .tmp_load(tmp_load), .tmp_din(tmp_din),
        .exec(exec), .op(op),
        .acc_q(acc_q), .tmp_q(tmp_q), .flags_q(flags_q)
    );

    task automatic cmp8(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        vectors++;
        cmp8(tag, "acc", int'(acc_q), m_acc);
        cmp8(tag, "tmp", int'(tmp_q), m_tmp);
        cmp8(tag, "flags", int'(flags_q), m_flags);
    endtask

    task automatic model_exec(input int o);
        int a, t, cin, s, r, cyo, ac, opnd, fl, ones;
        bit sub;
        a = m_acc; t = m_tmp;
        sub = (o == 2 || o == 3 || o == 7);
        cin = 0;
        if (o == 1) cin = m_cy;
        if (o == 2 || o == 7) cin = 1;
        if (o == 3) cin = 1 - m_cy;
        if (o < 4 || o == 7) begin
            opnd = sub ? ((~t) & 255) : t;
            s    = a + opnd + cin;
            r    = s % 256;
            cyo  = sub ? ((a - t - (o == 3 ? m_cy : 0)) < 0) : (s > 255);
            ac   = ((a % 16) + (opnd % 16) + cin) > 15;
        end else begin
            r   = (o == 4) ? (a & t) : (o == 5) ? (a ^ t) : (a | t);
            cyo = 0;
            ac  = (o == 4);
        end
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        fl = 2;
        if (r >= 128)       fl += 128;
        if (r == 0)         fl += 64;
        if (ac != 0)        fl += 16;
        if (ones % 2 == 0)  fl += 4;
        if (cyo != 0)       fl += 1;
        m_flags = fl;
        m_cy    = cyo;
        if (o != 7) m_acc = r;
    endtask

    task automatic step(input bit al, input int ad, input bit tl, input int td,
                        input bit ex, input int o, input string tag);
        acc_load = al; acc_din = ad[7:0];
        tmp_load = tl; tmp_din = td[7:0];
        exec = ex; op = o[2:0];
        @(posedge clk);
        @(negedge clk);
        if (ex) model_exec(o);
        else if (al) m_acc = ad;
        if (tl) m_tmp = td;
        check_all(tag);
    endtask

    task automatic load_both(input int a, input int t, input string tag);
        step(1'b1, a, 1'b1, t, 1'b0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_load = 1'b0; tmp_load = 1'b0; exec = 1'b0;
        acc_din = 8'h00; tmp_din = 8'h00; op = 3'd0;
        m_acc = 0; m_tmp = 0; m_flags = 2; m_cy = 0;
        acc_din = 8'hA5; tmp_din = 8'h5A; acc_load = 1'b1; tmp_load = 1'b1; exec = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        acc_load = 1'b0; tmp_load = 1'b0; exec = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 loads leave flags alone
        load_both(8'h3A, 8'h15, "R2");
        step(1'b0, 0, 1'b1, 8'h77, 1'b0, 0, "R2");
        step(1'b0, 0, 1'b1, 8'h15, 1'b0, 0, "R2");
        // R3 add and add with carry
        step(1'b0, 0, 1'b0, 0, 1'b1, 0, "R3");
        load_both(8'hFF, 8'h01, "R3");
        step(1'b0, 0, 1'b0, 0, 1'b1, 0, "R3");   // 00, Z CY AC
        load_both(8'h10, 8'h20, "R3");
        step(1'b0, 0, 1'b0, 0, 1'b1, 1, "R3");   // carry-in from prior CY
        // R8 half carry on add
        load_both(8'h0F, 8'h01, "R8");
        step(1'b0, 0, 1'b0, 0, 1'b1, 0, "R8");
        // R4 subtract and subtract with borrow
        load_both(8'h10, 8'h20, "R4");
        step(1'b0, 0, 1'b0, 0, 1'b1, 2, "R4");   // borrow
        load_both(8'h50, 8'h10, "R4");
        step(1'b0, 0, 1'b0, 0, 1'b1, 3, "R4");   // 50-10-1
        step(1'b0, 0, 1'b0, 0, 1'b1, 3, "R8");
        load_both(8'h00, 8'h00, "R4");
        step(1'b0, 0, 1'b0, 0, 1'b1, 2, "R4");
        // R5 logic group
        load_both(8'hF0, 8'h3C, "R5");
        step(1'b0, 0, 1'b0, 0, 1'b1, 4, "R5");
        step(1'b0, 0, 1'b0, 0, 1'b1, 5, "R5");
        step(1'b0, 0, 1'b0, 0, 1'b1, 6, "R5");
        load_both(8'h81, 8'h81, "R9");
        step(1'b0, 0, 1'b0, 0, 1'b1, 5, "R9");   // zero, even parity
        // R6 compare
        load_both(8'h40, 8'h41, "R6");
        step(1'b0, 0, 1'b0, 0, 1'b1, 7, "R6");
        step(1'b0, 0, 1'b0, 0, 1'b0, 0, "R6");
        // R10 exec beats acc_load, compare too
        step(1'b1, 8'h99, 1'b0, 0, 1'b1, 0, "R10");
        step(1'b1, 8'h99, 1'b0, 0, 1'b1, 7, "R10");
        // R11 same-edge operand load is not used
        load_both(8'h05, 8'h03, "R11");
        step(1'b0, 0, 1'b1, 8'h80, 1'b1, 0, "R11");
        step(1'b0, 0, 1'b0, 0, 1'b1, 0, "R11");
        // R7 layout over a long mixed run
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom);
            step(r[0], int'($urandom_range(0, 255)), r[1], int'($urandom_range(0, 255)),
                 r[2] | r[3], int'($urandom_range(0, 7)), "R7");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule